// File: doc/BRIEF.md
# Serial Flash Continuous-Read Host Engine

This block is the host side of a sequential read from a serial NOR flash. A single start pulse carries a page number, a byte offset within that page, a page-size mode and a choice between two read commands. The engine lowers chip select and shifts out the command byte. It then sends a 24-bit address, packed for the chosen page size, and the dummy bytes that command needs. Read data comes back one byte at a time on a valid/ready stream until the requested count is done. The flash keeps the data flowing across page boundaries on its own, so the engine never re-addresses and any non-zero count is allowed.

The serial clock comes from a divider of the system clock and follows SPI mode 0. It idles low, outgoing bits change on its falling edge, and incoming bits are sampled on its rising edge. All fields go out most significant bit first. The output stream has a single holding register. When the consumer holds ready low, the byte stays on `rd_data_o` with `rd_valid_o` high. The engine does not start clocking the next byte until that byte is taken. The serial clock pauses low while this happens and chip select stays asserted, so back-pressure only stretches the transfer.

Top module: `sflash_cread_host`

## Requirements
- R1: After reset `cs_n_o` is 1, `sck_o` is 0, `busy_o` is 0 and `rd_valid_o` is 0.
- R2: With `fast_i` = 0 the engine sends command byte 0xE8, then the 24 address bits, then 32 bits of zero.
- R3: With `fast_i` = 1 the engine sends command byte 0x0B, then the 24 address bits, then 8 bits of zero.
- R4: With `full_page_i` = 1 (264-byte pages) the 24-bit address is {6'b0, page[8:0], offset[8:0]}.
- R5: With `full_page_i` = 0 (256-byte pages) the 24-bit address is {7'b0, page[8:0], offset[7:0]}, and offset bit 8 is ignored.
- R6: Bits go out MSB first. `mosi_o` never changes while `sck_o` is high. `sck_o` is low whenever `cs_n_o` changes.
- R7: `cs_n_o` stays low from the first rising `sck_o` edge to the last one. One transaction has exactly header bits + 8 × count rising edges.
- R8: The returned bytes are the flash bytes at consecutive addresses from the start address, in order, for any count, including across page boundaries.
- R9: While `rd_valid_o` = 1 and `rd_ready_i` = 0, `rd_data_o` and `rd_valid_o` hold. No byte is lost or overwritten, and `sck_o` pauses low at the byte boundary.
- R10: `busy_o` is 1 from the accepted start until chip select has been high for two SCK half-periods. Between transactions `cs_n_o` stays high for at least 2 × CLK_DIV clock cycles.
- R11: A start while `busy_o` = 1 is ignored, and so is a start with `count_i` = 0.
- R12: Each high phase of `sck_o` lasts exactly CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| page_i | input | 9 | Page number |
| offset_i | input | 9 | Byte offset within the page |
| full_page_i | input | 1 | 1 = 264-byte pages, 0 = 256-byte pages |
| fast_i | input | 1 | 1 = 0x0B command with one dummy byte, 0 = 0xE8 command with four |
| count_i | input | 16 | Number of data bytes to read (0 = no transaction) |
| busy_o | output | 1 | Transaction or chip-select gap in progress |
| sck_o | output | 1 | Serial clock, mode 0 |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| rd_data_o | output | 8 | Returned byte |
| rd_valid_o | output | 1 | Returned byte is valid |
| rd_ready_i | input | 1 | Consumer accepts the byte |

## Verification
The bench runs both read commands in both page modes, so a wrong opcode, dummy length or address packing shows up in the captured header. Starts close to the end of a page and at offset bit 8 with 256-byte pages separate true page-boundary continuity and offset masking from a plain incrementing count. Ready is held high, toggled pseudo-randomly, and held low for long stretches. These three cases separate full-rate streaming, frequent short stalls and deep stalls at byte boundaries. A second start during a transfer and a start with a zero count show that ignored requests produce no extra chip-select cycle.

// File: rtl/sflash_rd_pkg.sv
package sflash_rd_pkg;
  localparam logic [7:0] CMD_LEGACY   = 8'hE8;
  localparam logic [7:0] CMD_FAST     = 8'h0B;
  localparam int         DUMMY_LEGACY = 4;
  localparam int         DUMMY_FAST   = 1;
  localparam int         ADDR_BITS    = 24;
  localparam int         HDR_MAX_BITS = 8 + ADDR_BITS + 8 * DUMMY_LEGACY;
  localparam int         HDR_FAST_BITS = 8 + ADDR_BITS + 8 * DUMMY_FAST;
  localparam int         HB_W         = $clog2(HDR_MAX_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP
  } xfer_st_e;
endpackage

// File: rtl/sflash_cmd_fmt.sv
module sflash_cmd_fmt
  import sflash_rd_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int OFF_W  = 9
) (
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [OFF_W-1:0]        offset_i,
  input  logic                    full_page_i,
  input  logic                    fast_i,
  output logic [HDR_MAX_BITS-1:0] hdr_o,
  output logic [HB_W-1:0]         hdr_bits_o
);
  localparam int FULL_W = PAGE_W + OFF_W;
  localparam int BIN_W  = PAGE_W + OFF_W - 1;

  logic [ADDR_BITS-1:0] addr;
  logic [7:0]           cmd;

  // Address packing depends on page mode; unused upper bits stay zero.
  always_comb begin
    addr = '0;
    if (full_page_i) begin
      addr[FULL_W-1:0] = {page_i, offset_i};
    end else begin
      addr[BIN_W-1:0] = {page_i, offset_i[OFF_W-2:0]};
    end
  end

  assign cmd        = fast_i ? CMD_FAST : CMD_LEGACY;
  assign hdr_o      = {cmd, addr, {(8 * DUMMY_LEGACY){1'b0}}};
  assign hdr_bits_o = fast_i ? HB_W'(HDR_FAST_BITS) : HB_W'(HDR_MAX_BITS);
endmodule

// File: rtl/sflash_sck_div.sv
module sflash_sck_div #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      logic [CW-1:0] cnt;
      assign tick_o = run_i && (cnt == CW'(CLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (!run_i || tick_o) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sflash_rx_byte.sv
module sflash_rx_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_i,
  input  logic       last_bit_i,
  input  logic       miso_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  input  logic       ready_i
);
  logic [6:0] sh;
  logic       byte_done;

  assign byte_done = sample_i && last_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (sample_i) begin
        sh <= {sh[5:0], miso_i};
      end
      if (byte_done) begin
        data_o  <= {sh, miso_i};
        valid_o <= 1'b1;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R9
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !valid_o); // R9
endmodule

// File: rtl/sflash_cread_host.sv
module sflash_cread_host
  import sflash_rd_pkg::*;
#(
  parameter int PAGE_W  = 9,
  parameter int OFF_W   = 9,
  parameter int CNT_W   = 16,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              full_page_i,
  input  logic              fast_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i
);
  xfer_st_e                st;
  logic [HDR_MAX_BITS-1:0] hdr_w;
  logic [HB_W-1:0]         hb_w;
  logic [HDR_MAX_BITS-1:0] tx_sh;
  logic [HB_W-1:0]         hb_q;
  logic [HB_W-1:0]         hcnt;
  logic                    in_data;
  logic [2:0]              dbit;
  logic [CNT_W-1:0]        left;
  logic                    done_q;
  logic                    gap_half;
  logic                    tick;
  logic                    stall;
  logic                    run;
  logic                    rise;
  logic                    fall;
  logic                    accept;

  sflash_cmd_fmt #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_fmt (
    .page_i      (page_i),
    .offset_i    (offset_i),
    .full_page_i (full_page_i),
    .fast_i      (fast_i),
    .hdr_o       (hdr_w),
    .hdr_bits_o  (hb_w)
  );

  // Hold the clock low at a byte boundary while the output byte is unread.
  assign stall  = (st == ST_XFER) && in_data && (dbit == 3'd0) && !sck_o && rd_valid_o;
  assign run    = (st != ST_IDLE) && !stall;
  assign rise   = tick && (st == ST_XFER) && !sck_o;
  assign fall   = tick && (st == ST_XFER) && sck_o;
  assign accept = (st == ST_IDLE) && start_i && (count_i != '0);
  assign busy_o = (st != ST_IDLE);

  sflash_sck_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  sflash_rx_byte u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (rise && in_data),
    .last_bit_i (dbit == 3'd7),
    .miso_i     (miso_i),
    .data_o     (rd_data_o),
    .valid_o    (rd_valid_o),
    .ready_i    (rd_ready_i)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sck_o    <= 1'b0;
      cs_n_o   <= 1'b1;
      mosi_o   <= 1'b0;
      tx_sh    <= '0;
      hb_q     <= '0;
      hcnt     <= '0;
      in_data  <= 1'b0;
      dbit     <= '0;
      left     <= '0;
      done_q   <= 1'b0;
      gap_half <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st      <= ST_XFER;
            cs_n_o  <= 1'b0;
            mosi_o  <= hdr_w[HDR_MAX_BITS-1];
            tx_sh   <= hdr_w << 1;
            hb_q    <= hb_w;
            hcnt    <= '0;
            in_data <= 1'b0;
            dbit    <= '0;
            left    <= count_i;
            done_q  <= 1'b0;
          end
        end
        ST_XFER: begin
          if (rise) begin
            sck_o <= 1'b1;
            if (!in_data) begin
              if (hcnt == hb_q - 1'b1) begin
                in_data <= 1'b1;
                dbit    <= '0;
              end else begin
                hcnt <= hcnt + 1'b1;
              end
            end else begin
              dbit <= dbit + 1'b1;
              if (dbit == 3'd7) begin
                left <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                  done_q <= 1'b1;
                end
              end
            end
          end else if (fall) begin
            sck_o <= 1'b0;
            if (done_q) begin
              cs_n_o   <= 1'b1;
              mosi_o   <= 1'b0;
              st       <= ST_GAP;
              gap_half <= 1'b0;
            end else begin
              mosi_o <= tx_sh[HDR_MAX_BITS-1];
              tx_sh  <= tx_sh << 1;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) begin
              st <= ST_IDLE;
            end else begin
              gap_half <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_CS_EDGE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cs_n_o) |-> !sck_o); // R6
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o && $past(sck_o) |-> $stable(mosi_o)); // R6
  AST_SCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !cs_n_o); // R7
  AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o); // R10
endmodule

// File: tb/test_sflash_cread_host.sv
module test_sflash_cread_host;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [8:0]  page_i = '0;
  logic [8:0]  offset_i = '0;
  logic        full_page_i = 1'b0;
  logic        fast_i = 1'b0;
  logic [15:0] count_i = '0;
  logic        busy_o, sck_o, cs_n_o, mosi_o;
  logic        miso_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o;
  logic        rd_ready_i = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sflash_cread_host #(.CLK_DIV(DIV)) i_sflash_cread_host (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
    .offset_i(offset_i), .full_page_i(full_page_i), .fast_i(fast_i),
    .count_i(count_i), .busy_o(busy_o), .sck_o(sck_o), .cs_n_o(cs_n_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ {a[23:17], 1'b0} ^ 8'h5A;
  endfunction

  // Expectations for the transaction in flight
  logic [7:0]  q[$];
  int          exp_hb = 64;
  int          exp_rises = 0;
  bit          exp_fast = 1'b0;
  logic [23:0] exp_addr = '0;
  int          bp_mode = 0;
  int          cs_falls = 0;

  // Flash model and monitor state
  bit          sck_prev = 1'b0, cs_prev = 1'b1, mosi_prev = 1'b0;
  int          rise_n = 0;
  logic [63:0] cap = '0, snap = '0;
  logic [23:0] m_addr = '0;
  int          hi_cnt = 0, gap_cnt = 0;
  bit          first_done = 1'b0;
  bit          hi_err = 1'b0, mosi_err = 1'b0, hold_err = 1'b0;
  bit          pv_valid = 1'b0, pv_ready = 1'b0;
  logic [7:0]  pv_data = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    if (rst_n) begin
      // ready for the coming edge, decided before sampling the handshake
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (bp_mode)
        0: rd_ready_i = 1'b1;
        1: rd_ready_i = lfsr[0];
        default: rd_ready_i = (lfsr[3:0] == 4'h0);
      endcase
      // R9: a stalled byte holds
      if (pv_valid && !pv_ready && (!rd_valid_o || rd_data_o != pv_data)) hold_err = 1'b1;
      if (rd_valid_o && rd_ready_i) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected byte", rd_data_o, 0);
        end else begin
          logic [7:0] e;
          e = q.pop_front();
          check(rd_data_o == e, "R8 data byte", rd_data_o, e);
        end
      end
      pv_valid = rd_valid_o; pv_ready = rd_ready_i; pv_data = rd_data_o;

      // chip select edges
      if (cs_prev && !cs_n_o) begin
        cs_falls++;
        if (first_done) check(gap_cnt >= 2 * DIV, "R10 cs high gap", gap_cnt, 2 * DIV);
        check(!sck_o && busy_o, "R6 sck low at cs fall", sck_o, 0);
        rise_n = 0; cap = '0; hi_err = 1'b0; mosi_err = 1'b0;
      end
      if (!cs_prev && cs_n_o) begin
        first_done = 1'b1;
        check(!sck_o, "R6 sck low at cs rise", sck_o, 0);
        check(rise_n == exp_rises, "R7 rising edges under cs", rise_n, exp_rises);
        check(!hi_err, "R12 sck high time", hi_err, 0);
        check(!mosi_err, "R6 mosi stable while sck high", mosi_err, 0);
        if (exp_fast) begin
          check(snap[39:32] == 8'h0B, "R3 opcode", snap[39:32], 8'h0B);
          check(snap[31:8] == exp_addr, "R4 R5 address", snap[31:8], exp_addr);
          check(snap[7:0] == 8'h00, "R3 dummy byte", snap[7:0], 0);
        end else begin
          check(snap[63:56] == 8'hE8, "R2 opcode", snap[63:56], 8'hE8);
          check(snap[55:32] == exp_addr, "R4 R5 address", snap[55:32], exp_addr);
          check(snap[31:0] == 32'h0, "R2 dummy bytes", snap[31:0], 0);
        end
      end
      gap_cnt = cs_n_o ? gap_cnt + 1 : 0;

      // serial clock edges
      if (!cs_n_o) begin
        if (sck_o && sck_prev && mosi_o != mosi_prev) mosi_err = 1'b1;
        if (sck_o && !sck_prev) begin
          if (rise_n < 64) cap = {cap[62:0], mosi_o};
          rise_n++;
          if (rise_n == exp_hb) begin
            snap   = cap;
            m_addr = exp_fast ? cap[31:8] : cap[55:32];
          end
        end
        if (!sck_o && sck_prev) begin
          if (hi_cnt != DIV) hi_err = 1'b1;
          if (rise_n >= exp_hb) begin
            int k;
            logic [7:0] b;
            k = rise_n - exp_hb;
            b = pat(m_addr + 24'(k / 8));
            miso_i = b[7 - (k % 8)];
          end
        end
      end
      hi_cnt = sck_o ? hi_cnt + 1 : 0;
      sck_prev = sck_o; cs_prev = cs_n_o; mosi_prev = mosi_o;
    end
  end

  task automatic pulse_start(input logic [8:0] pg, input logic [8:0] off, input bit full,
                             input bit fast, input logic [15:0] cnt);
    page_i = pg; offset_i = off; full_page_i = full; fast_i = fast; count_i = cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_txn(input logic [8:0] pg, input logic [8:0] off, input bit full,
                         input bit fast, input int cnt, input int bp, input bit extra);
    logic [23:0] a;
    int falls0;
    a = full ? {6'b0, pg, off} : {7'b0, pg, off[7:0]};
    exp_addr  = a;
    exp_fast  = fast;
    exp_hb    = fast ? 40 : 64;
    exp_rises = exp_hb + 8 * cnt;
    bp_mode   = bp;
    hold_err  = 1'b0;
    for (int i = 0; i < cnt; i++) q.push_back(pat(a + 24'(i)));
    falls0 = cs_falls;
    @(negedge clk);
    pulse_start(pg, off, full, fast, 16'(cnt));
    if (extra) begin
      repeat (30) @(negedge clk);
      check(busy_o, "R11 busy during transfer", busy_o, 1);
      pulse_start(9'd1, 9'd2, 1'b1, ~fast, 16'd9);
    end
    while (busy_o) @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(cs_falls - falls0 == 1, "R11 one cs cycle per start", cs_falls - falls0, 1);
    check(!hold_err, "R9 stalled byte held", hold_err, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(cs_n_o && !sck_o && !busy_o && !rd_valid_o, "R1 reset state",
              {cs_n_o, sck_o, busy_o, rd_valid_o}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n_o && !busy_o, "R1 idle after reset", {cs_n_o, busy_o}, 2'b10);
        run_txn(9'd5,   9'd10,  1'b1, 1'b0, 4,  0, 1'b0); // R2 R4 full rate
        run_txn(9'd7,   9'd262, 1'b1, 1'b1, 5,  1, 1'b0); // R3 R8 page crossing
        run_txn(9'd300, 9'h1F0, 1'b0, 1'b0, 20, 1, 1'b0); // R5 offset bit 8 ignored
        run_txn(9'd511, 9'd255, 1'b0, 1'b1, 3,  0, 1'b1); // R11 start while busy
        run_txn(9'd0,   9'd0,   1'b1, 1'b1, 1,  2, 1'b0); // R9 deep stalls
        run_txn(9'd2,   9'd263, 1'b1, 1'b0, 6,  2, 1'b0); // R9 R10 back to back
        pulse_start(9'd3, 9'd4, 1'b1, 1'b1, 16'd0);
        repeat (20) @(negedge clk);
        check(!busy_o && cs_n_o, "R11 zero count ignored", {busy_o, cs_n_o}, 2'b01);
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule